// File: doc/BRIEF.md
# Partitioned NV-SRAM Chip-Enable Decoder

This block sits between the program and data requests of an 8-bit controller core and a byte-wide, non-multiplexed SRAM bus. Each request is classified into one of three outcomes. It can select battery-backed SRAM, select one of four peripheral devices in a second 64 kB data space, or hand the cycle to the multiplexed expansion bus. Writes that land in a region classed as code never get a write strobe.

Software sets the mapping through a small register port. In the fixed layout, separate upper limits bound the mapped program and data spaces. In the split layout, a single 64 kB RAM holds code below a movable boundary and data above it. Data address zero maps to the boundary. A bank-switch bit makes the code area readable as data, up to 60 kB of it. A size input picks the 128 kB single-device wiring. In that wiring, one extra address bit separates program from data, and the split layout is ignored.

A five-state machine registers each decision and drives the bus one cycle after the request.
- `ST_HELD` is entered on reset or power-fail hold.
- `ST_IDLE` is entered when there is no request.
- `ST_SRAM`, `ST_PERIPH` and `ST_EXPAND` follow the decoded outcome.

Every state can move to every other at any clock edge. Hold takes priority, and no request gives `ST_IDLE`; otherwise the decoded outcome picks the next state. The power-fail hold also drives every strobe inactive at once, without waiting for a clock edge.

Top module: `nvbus_decode`

## Requirements
- R1: Reset leaves the state machine in `ST_HELD` with every active-low enable and `rw_n` high, `exp_sel` low and `bus_addr` zero. The configuration resets to the fixed layout, with peripheral mode off, bank switch off, both range limits at 4'hF and the boundary at 0.
- R2: Configuration writes take effect at the clock edge where `cfg_we` is high. The register map is:
  - `cfg_addr` 0: bit0 selects the fixed layout (1) or the split layout (0), bit1 enables peripheral mode and bit2 enables the bank switch.
  - `cfg_addr` 1: bits [3:0] hold the program limit.
  - `cfg_addr` 2: bits [3:0] hold the data limit.
  - `cfg_addr` 3: bits [3:0] hold the boundary, in 4 kB units.

  A request sampled at the same edge as a write is decoded with the values from before the write.
- R3: A request sampled at a clock edge drives the outputs until the next edge. A cycle with `req_valid` low leaves all enables high, `exp_sel` low and `bus_addr` zero.
- R4: In the fixed layout, a program access maps to SRAM if address bits [15:12] are at most the program limit. It asserts `ram_ce_n[0]` with `bus_addr` = {0, address}. Any other program access goes to the expansion bus (`exp_sel`=1, `bus_addr` = {0, address}).
- R5: In the fixed layout, a data access maps to SRAM if address bits [15:12] are at most the data limit, with `bus_addr` = {1, address}. With `msel128`=0 it asserts `ram_ce_n[1]`; with `msel128`=1 it asserts `ram_ce_n[0]`. Any other data access goes to the expansion bus.
- R6: In the split layout with `msel128`=0, let B be the boundary × 4096:
  - A program access below B maps to SRAM on `ram_ce_n[0]` at {0, address}, and any other program access goes to expansion.
  - A data access maps to B + address on `ram_ce_n[0]` if that sum is below 65536, and otherwise goes to expansion.
- R7: With `msel128`=1 the split-layout setting is ignored, and decoding follows R4 and R5. `ram_ce_n[1]` is then never asserted.
- R8: In peripheral mode, every data access asserts `per_ce_n[address[15:14]]` with `bus_addr` = {0, address}. Program accesses keep decoding as in R4 and R6.
- R9: With the bank switch on and peripheral mode off, some data accesses reach the code area. They map to SRAM on `ram_ce_n[0]` at {0, address}. The addresses covered are:
  - in the fixed layout, those whose bits [15:12] are at most the program limit and not 4'hF;
  - in the split layout, those below B.

  Other data accesses follow R5 or R6.
- R10: `rw_n` goes low only for a write request mapped to SRAM or a peripheral, and not in the code area. Program-space writes and bank-switched writes keep `rw_n` high while still asserting the chip enable. Expansion cycles keep `rw_n` high.
- R11: While `pf_hold` is high, all enables and `rw_n` are high, `exp_sel` is low and `bus_addr` is zero in the same cycle. After `pf_hold` falls, decoding resumes from the next sampled request.
- R12: At most one of the six enables and `exp_sel` is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_hold | input | 1 | Power-fail / reset hold, forces outputs inactive |
| msel128 | input | 1 | 1 = single 128 kB SRAM wiring |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 4 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_is_code | input | 1 | 1 = program space, 0 = data space |
| req_write | input | 1 | 1 = write cycle |
| req_addr | input | 16 | Logical address |
| ram_ce_n | output | 2 | Active-low SRAM chip enables |
| per_ce_n | output | 4 | Active-low peripheral chip enables |
| rw_n | output | 1 | Active-low write strobe |
| exp_sel | output | 1 | Cycle handed to expansion bus |
| bus_addr | output | 17 | Byte-wide bus address |

## Verification
The two functions that can coincide are a configuration write and the decoding of a request sampled at the same edge. A power-fail hold arriving while a request is being decoded is a second pair. The bench provokes both by issuing random register writes and hold pulses in the same cycles as random requests, plus directed cases that move the boundary and switch modes exactly on an access. Its model decodes each request against its copy of the configuration from before the write, then applies the write. Hold cycles are judged both right after the input changes and after the edge.

// File: rtl/nvd_pkg.sv
package nvd_pkg;
    localparam int ADDR_W   = 16;
    localparam int SEG_W    = 4;
    localparam int PER_N    = 4;
    localparam int RAM_CE_N = 2;
    localparam int CFG_AW   = 2;
    localparam int CFG_DW   = SEG_W;
    localparam int PSEL_W   = $clog2(PER_N);
    localparam int RSEL_W   = $clog2(RAM_CE_N);
    localparam int PHYS_W   = ADDR_W + 1;
    localparam int OFS_W    = ADDR_W - SEG_W;
    localparam logic [SEG_W-1:0] SEG_TOP = {SEG_W{1'b1}};

    typedef enum logic [2:0] {
        ST_HELD,
        ST_IDLE,
        ST_SRAM,
        ST_PERIPH,
        ST_EXPAND
    } bus_state_e;

    typedef struct packed {
        logic             fixed_map;
        logic             periph_on;
        logic             bank_on;
        logic [SEG_W-1:0] prog_lim;
        logic [SEG_W-1:0] data_lim;
        logic [SEG_W-1:0] bound;
    } cfg_t;

    typedef struct packed {
        bus_state_e        kind;
        logic [RSEL_W-1:0] ram_sel;
        logic [PSEL_W-1:0] per_sel;
        logic [PHYS_W-1:0] phys;
        logic              wr_ok;
    } route_t;
endpackage

// File: rtl/nvd_cfg_regs.sv
module nvd_cfg_regs
    import nvd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output cfg_t              cfg
);
    logic unused_mode_bit;
    assign unused_mode_bit = wdata[CFG_DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.fixed_map <= 1'b1;
            cfg.periph_on <= 1'b0;
            cfg.bank_on   <= 1'b0;
            cfg.prog_lim  <= SEG_TOP;
            cfg.data_lim  <= SEG_TOP;
            cfg.bound     <= '0;
        end else if (we) begin
            unique case (addr)
                2'd0: begin
                    cfg.fixed_map <= wdata[0];
                    cfg.periph_on <= wdata[1];
                    cfg.bank_on   <= wdata[2];
                end
                2'd1: cfg.prog_lim <= wdata[SEG_W-1:0];
                2'd2: cfg.data_lim <= wdata[SEG_W-1:0];
                2'd3: cfg.bound    <= wdata[SEG_W-1:0];
                default: ;
            endcase
        end
    end

    // R2: registers change only on a write strobe
    a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg));
endmodule

// File: rtl/nvd_addr_map.sv
module nvd_addr_map
    import nvd_pkg::*;
(
    input  cfg_t              cfg,
    input  logic              msel128,
    input  logic              is_code,
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);
    logic              split;
    logic [SEG_W-1:0]  seg;
    logic [ADDR_W-1:0] bound_addr;
    logic [PHYS_W-1:0] shifted;
    logic              below_bound;
    logic              prog_hit_fixed;
    logic              bank_hit;

    always_comb begin
        split          = !cfg.fixed_map && !msel128;
        seg            = addr[ADDR_W-1 -: SEG_W];
        bound_addr     = {cfg.bound, {OFS_W{1'b0}}};
        shifted        = {1'b0, addr} + {1'b0, bound_addr};
        below_bound    = addr < bound_addr;
        prog_hit_fixed = seg <= cfg.prog_lim;
        bank_hit       = split ? below_bound : (prog_hit_fixed && seg != SEG_TOP);

        route.kind    = ST_EXPAND;
        route.ram_sel = '0;
        route.per_sel = '0;
        route.phys    = {1'b0, addr};
        route.wr_ok   = 1'b0;

        if (is_code) begin
            if (split ? below_bound : prog_hit_fixed) begin
                route.kind = ST_SRAM;
            end
        end else if (cfg.periph_on) begin
            route.kind    = ST_PERIPH;
            route.per_sel = addr[ADDR_W-1 -: PSEL_W];
            route.wr_ok   = 1'b1;
        end else if (cfg.bank_on && bank_hit) begin
            route.kind = ST_SRAM;
        end else if (split) begin
            if (!shifted[PHYS_W-1]) begin
                route.kind  = ST_SRAM;
                route.phys  = {1'b0, shifted[ADDR_W-1:0]};
                route.wr_ok = 1'b1;
            end
        end else if (seg <= cfg.data_lim) begin
            route.kind    = ST_SRAM;
            route.ram_sel = RSEL_W'(!msel128);
            route.phys    = {1'b1, addr};
            route.wr_ok   = 1'b1;
        end
    end
endmodule

// File: rtl/nvd_bus_fsm.sv
module nvd_bus_fsm
    import nvd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pf_hold,
    input  logic                req_valid,
    input  logic                req_write,
    input  route_t              route,
    output logic [RAM_CE_N-1:0] ram_ce_n,
    output logic [PER_N-1:0]    per_ce_n,
    output logic                rw_n,
    output logic                exp_sel,
    output logic [PHYS_W-1:0]   bus_addr
);
    bus_state_e state, state_nx;
    route_t     rt_q;
    logic       wr_q;

    always_comb begin
        if (pf_hold)         state_nx = ST_HELD;
        else if (!req_valid) state_nx = ST_IDLE;
        else                 state_nx = route.kind;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HELD;
            rt_q  <= '0;
            wr_q  <= 1'b0;
        end else begin
            state <= state_nx;
            rt_q  <= route;
            wr_q  <= req_write && route.wr_ok;
        end
    end

    always_comb begin
        ram_ce_n = '1;
        per_ce_n = '1;
        rw_n     = 1'b1;
        exp_sel  = 1'b0;
        bus_addr = '0;
        unique case (state)
            ST_HELD, ST_IDLE: ;
            ST_SRAM: begin
                ram_ce_n[rt_q.ram_sel] = 1'b0;
                rw_n     = !wr_q;
                bus_addr = rt_q.phys;
            end
            ST_PERIPH: begin
                per_ce_n[rt_q.per_sel] = 1'b0;
                rw_n     = !wr_q;
                bus_addr = rt_q.phys;
            end
            ST_EXPAND: begin
                exp_sel  = 1'b1;
                bus_addr = rt_q.phys;
            end
            default: ;
        endcase
        if (pf_hold) begin
            ram_ce_n = '1;
            per_ce_n = '1;
            rw_n     = 1'b1;
            exp_sel  = 1'b0;
            bus_addr = '0;
        end
    end

    // R11: hold forces every strobe inactive
    a_r11_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        pf_hold |-> (&ram_ce_n && &per_ce_n && rw_n && !exp_sel));
    // R12: one target at most
    a_r12_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_ce_n, ~per_ce_n, exp_sel}));
    // R10: expansion cycles never strobe the byte-wide bus
    a_r10_exp_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        exp_sel |-> rw_n);
    // R3: an empty request cycle leaves the bus quiet
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (&ram_ce_n && &per_ce_n && !exp_sel));
endmodule

// File: rtl/nvbus_decode.sv
module nvbus_decode
    import nvd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pf_hold,
    input  logic                msel128,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic                req_valid,
    input  logic                req_is_code,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic [RAM_CE_N-1:0] ram_ce_n,
    output logic [PER_N-1:0]    per_ce_n,
    output logic                rw_n,
    output logic                exp_sel,
    output logic [PHYS_W-1:0]   bus_addr
);
    cfg_t   cfg;
    route_t route;

    nvd_cfg_regs i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    nvd_addr_map i_map (
        .cfg     (cfg),
        .msel128 (msel128),
        .is_code (req_is_code),
        .addr    (req_addr),
        .route   (route)
    );

    nvd_bus_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_hold   (pf_hold),
        .req_valid (req_valid),
        .req_write (req_write),
        .route     (route),
        .ram_ce_n  (ram_ce_n),
        .per_ce_n  (per_ce_n),
        .rw_n      (rw_n),
        .exp_sel   (exp_sel),
        .bus_addr  (bus_addr)
    );

    // R10: program-space writes never strobe
    a_r10_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_code) |=> rw_n);
    // R7: single-device wiring never uses the second SRAM enable
    a_r7_single_chip: assert property (@(posedge clk) disable iff (!rst_n)
        (msel128 && $past(msel128)) |-> ram_ce_n[1]);
endmodule

// File: tb/test_nvbus_decode.sv
module test_nvbus_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pf_hold = 1'b0;
    logic        msel128 = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_is_code = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  ram_ce_n;
    logic [3:0]  per_ce_n;
    logic        rw_n;
    logic        exp_sel;
    logic [16:0] bus_addr;

    typedef struct packed {
        logic [1:0]  rce;
        logic [3:0]  pce;
        logic        rw;
        logic        ex;
        logic [16:0] ba;
    } obs_t;

    localparam obs_t QUIET = '{rce: 2'b11, pce: 4'hF, rw: 1'b1, ex: 1'b0, ba: 17'h0};

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic       m_fixed, m_per, m_bank;
    logic [3:0] m_pl, m_dl, m_bd;

    always #5 clk = ~clk;

    nvbus_decode i_nvbus_decode (
        .clk(clk), .rst_n(rst_n), .pf_hold(pf_hold), .msel128(msel128),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_is_code(req_is_code), .req_write(req_write),
        .req_addr(req_addr), .ram_ce_n(ram_ce_n), .per_ce_n(per_ce_n),
        .rw_n(rw_n), .exp_sel(exp_sel), .bus_addr(bus_addr)
    );

    function automatic obs_t observe();
        obs_t o;
        o.rce = ram_ce_n; o.pce = per_ce_n; o.rw = rw_n; o.ex = exp_sel; o.ba = bus_addr;
        return o;
    endfunction

    function automatic obs_t model(logic hold, logic v, logic c, logic w, logic [15:0] a, logic m);
        obs_t o;
        logic split;
        int   bnd, sum;
        o = QUIET;
        if (hold || !v) return o;
        split = !m_fixed && !m;
        bnd   = int'(m_bd) * 4096;
        sum   = int'(a) + bnd;
        o.ex  = 1'b1;
        o.ba  = {1'b0, a};
        if (c) begin
            if (split ? (int'(a) < bnd) : (a[15:12] <= m_pl)) begin
                o.ex = 1'b0; o.rce = 2'b10;
            end
        end else if (m_per) begin
            o.ex = 1'b0; o.pce = ~(4'b0001 << a[15:14]); o.rw = !w;
        end else if (m_bank && (split ? (int'(a) < bnd) : (a[15:12] <= m_pl && a[15:12] != 4'hF))) begin
            o.ex = 1'b0; o.rce = 2'b10;
        end else if (split) begin
            if (sum < 65536) begin
                o.ex = 1'b0; o.rce = 2'b10; o.rw = !w; o.ba = 17'(sum);
            end
        end else if (a[15:12] <= m_dl) begin
            o.ex = 1'b0; o.rce = m ? 2'b10 : 2'b01; o.rw = !w; o.ba = {1'b1, a};
        end
        return o;
    endfunction

    task automatic check(string tag, obs_t got, obs_t exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got rce=%b pce=%b rw=%b ex=%b ba=%h exp rce=%b pce=%b rw=%b ex=%b ba=%h",
                     tag, got.rce, got.pce, got.rw, got.ex, got.ba,
                     exp.rce, exp.pce, exp.rw, exp.ex, exp.ba);
        end
    endtask

    task automatic model_write(logic [1:0] wa, logic [3:0] wd);
        case (wa)
            2'd0: begin m_fixed = wd[0]; m_per = wd[1]; m_bank = wd[2]; end
            2'd1: m_pl = wd;
            2'd2: m_dl = wd;
            default: m_bd = wd;
        endcase
    endtask

    // called at a negedge; returns at the following negedge after checking
    task automatic step(string tag, logic h, logic v, logic c, logic w, logic [15:0] a,
                        logic we, logic [1:0] wa, logic [3:0] wd);
        obs_t e;
        pf_hold = h; req_valid = v; req_is_code = c; req_write = w; req_addr = a;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        e = model(h, v, c, w, a, msel128);
        if (h) begin
            #1 check({tag, " R11 same-cycle"}, observe(), QUIET);
        end
        @(negedge clk);
        check(tag, observe(), e);
        if (we) model_write(wa, wd);
    endtask

    task automatic acc(string tag, logic c, logic w, logic [15:0] a);
        step(tag, 1'b0, 1'b1, c, w, a, 1'b0, 2'd0, 4'd0);
    endtask

    task automatic wr(logic [1:0] wa, logic [3:0] wd);
        step("R2 cfg write idle", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, wa, wd);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_0a41));
        m_fixed = 1; m_per = 0; m_bank = 0; m_pl = 4'hF; m_dl = 4'hF; m_bd = 4'h0;
        req_valid = 1'b1; req_is_code = 1'b1; req_addr = 16'h1234;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", observe(), QUIET);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first after reset", observe(), model(0, 1, 1, 0, 16'h1234, 0));
        acc("R1 reset prog limit full", 1, 0, 16'hFFFF);
        acc("R1 reset data limit full", 0, 0, 16'hFFFF);
        acc("R5 data two-chip", 0, 0, 16'h1234);
        acc("R5 data write strobe", 0, 1, 16'h1234);
        acc("R10 code write blocked", 1, 1, 16'h0100);
        step("R3 idle", 0, 0, 0, 0, 16'h4444, 0, 0, 0);
        wr(2'd1, 4'h3);
        acc("R4 prog above limit", 1, 0, 16'h4000);
        acc("R4 prog at limit edge", 1, 0, 16'h3FFF);
        wr(2'd2, 4'h7);
        acc("R5 data above limit", 0, 0, 16'h8000);
        acc("R5 data at limit", 0, 1, 16'h7FFF);
        wr(2'd1, 4'hF); wr(2'd2, 4'hF);
        wr(2'd3, 4'h4); wr(2'd0, 4'h0);
        acc("R6 prog below bound", 1, 0, 16'h3FFF);
        acc("R6 prog at bound", 1, 0, 16'h4000);
        acc("R6 data zero offset", 0, 1, 16'h0000);
        acc("R6 data last", 0, 0, 16'hBFFF);
        acc("R6 data overflow", 0, 0, 16'hC000);
        // R2: write in same cycle as access uses the old boundary
        step("R2 same-cycle write", 0, 1, 0, 0, 16'h0010, 1, 2'd3, 4'h8);
        acc("R2 new boundary", 0, 0, 16'h0010);
        msel128 = 1'b1;
        acc("R7 split ignored prog", 1, 0, 16'h9000);
        acc("R7 single chip data", 0, 1, 16'h0010);
        msel128 = 1'b0;
        wr(2'd0, 4'h4);
        acc("R9 bank split code read", 0, 0, 16'h2000);
        acc("R9 bank split write blocked", 0, 1, 16'h2000);
        acc("R9 bank split above bound", 0, 0, 16'h8000);
        wr(2'd0, 4'h5);
        acc("R9 bank fixed code read", 0, 1, 16'h2000);
        acc("R9 bank fixed top excluded", 0, 0, 16'hF000);
        wr(2'd0, 4'h7);
        acc("R8 periph select 3", 0, 1, 16'hC005);
        acc("R8 periph select 1", 0, 0, 16'h4005);
        acc("R8 code unaffected", 1, 0, 16'h4005);
        step("R11 hold mid request", 1, 1, 0, 1, 16'h0005, 0, 0, 0);
        acc("R11 after release", 0, 1, 16'h8001);
        wr(2'd0, 4'h1);
        for (int i = 0; i < 3000; i++) begin
            logic h, v, we;
            if (($urandom % 64) == 0) msel128 = ~msel128;
            h  = (($urandom % 32) == 0);
            v  = (($urandom % 4) != 0);
            we = (($urandom % 8) == 0);
            step("R12 random", h, v, 1'($urandom), 1'($urandom), 16'($urandom),
                 we, 2'($urandom), 4'($urandom));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule